// File: doc/BRIEF.md
# Serial Programming Port Target

This block is the device end of a two-wire programming link. An external programmer drives a serial clock and a data line. The data line is shared: the programmer drives it for commands and operands, and the device drives it for read data, with a separate output enable. Every transaction is a 4-bit command followed by a 16-bit operand. Both fields are sent least significant bit first, one bit per serial clock.

Two commands are acted on. The first feeds one core instruction through the operand. The supported instructions load a literal into a working register or copy that register into one byte of a 22-bit table pointer. The second command reads one byte of memory at the table pointer. During the first half of the operand the data line is still an input. The device then takes the line and shifts the byte out over the last eight clocks, after which the pointer steps forward by one.

The serial clock is not related to the system clock. Both external lines are resynchronised, and all serial activity is detected as edges on the resynchronised clock. The link has no flow control, so it carries no valid/ready handshake: the programmer sets the pace, and the device only has to see each serial half-period for a few system clocks.

Top module: `pgm_port_target`

## Requirements
- R1: A transaction starts with 4 command bits taken from `sdata_in`, least significant bit first, on successive falling edges of `sclk`. These are followed by 16 operand bits, also least significant bit first.
- R2: Command 4'b0000 executes the operand as a core instruction after its 16th falling edge. The opcode is operand[15:8] and the argument is operand[7:0]. Opcode 8'h0E loads the argument into the working register.
- R3: Opcode 8'h6E copies the working register into the pointer byte named by the argument. 8'hF8 selects the upper byte, which keeps only its low 6 bits (pointer[21:16]). 8'hF7 selects pointer[15:8] and 8'hF6 selects pointer[7:0].
- R4: A core instruction with any other opcode, or opcode 8'h6E with any other argument, changes neither the working register nor the pointer.
- R5: Command 4'b1001 ignores the first 8 operand bits and returns the byte at the pointer over operand clocks 9 to 16, least significant bit first. Each bit changes on a rising edge of `sclk` and is valid at the next falling edge.
- R6: `sdata_oe` stays low through the first 8 operand clocks of a read. It rises only after the 8th falling edge, while `sclk` is held low, and falls after the 16th falling edge.
- R7: Each read adds one to the 22-bit pointer afterwards, wrapping from 22'h3FFFFF to 22'h000000.
- R8: The memory byte at address A is 8'hA5 XOR A[7:0] XOR A[15:8] XOR {2'b00, A[21:16]}. It is read synchronously.
- R9: Any other command code takes its 16 operand clocks with `sdata_oe` kept low and changes no state.
- R10: While `rst_n` is low, `sdata_oe` and `sdata_out` are low and the pointer and working register are zero. After reset the block waits for a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from programmer |
| sdata_in | input | 1 | Data line as seen by the device |
| sdata_out | output | 1 | Data driven onto the line during reads |
| sdata_oe | output | 1 | Drive enable for the data line |

## Verification
On every cycle the assertions check several rules. The output enable may change only in the cycle after a detected falling serial edge. The output bit may change only after a detected rising edge. A post-increment must advance the pointer by exactly one, modulo 2^22. The working register must hold whenever no instruction executes. Some behaviour only the bench scenarios can show: bit order on the line, correct decoding of the three pointer bytes, the content formula, wrap-around at the top of the address space, and that unsupported instructions and unknown commands leave later reads unchanged.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int CMD_W  = 4;
  localparam int OPER_W = 16;
  localparam int ADDR_W = 22;
  localparam int BYTE_W = 8;

  localparam logic [CMD_W-1:0] CMD_CORE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_TBLRD = 4'b1001;

  localparam logic [7:0] OPC_LOADW = 8'h0E;
  localparam logic [7:0] OPC_STORW = 8'h6E;
  localparam logic [7:0] REG_UPPER = 8'hF8;
  localparam logic [7:0] REG_HIGH  = 8'hF7;
  localparam logic [7:0] REG_LOW   = 8'hF6;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_OPER,
    PH_OUT
  } phase_t;
endpackage

// File: rtl/pgm_edge_sync.sv
module pgm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_raw,
  input  logic data_raw,
  output logic rise_evt,
  output logic fall_evt,
  output logic data_syn
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], sclk_raw};
      dat_pipe <= {dat_pipe[STAGES-2:0], data_raw};
      clk_prev <= clk_pipe[STAGES-1];
    end
  end

  assign rise_evt = clk_pipe[STAGES-1] & ~clk_prev;
  assign fall_evt = ~clk_pipe[STAGES-1] & clk_prev;
  assign data_syn = dat_pipe[STAGES-1];
endmodule

// File: rtl/pgm_mem_model.sv
module pgm_mem_model #(
  parameter int AW   = 22,
  parameter int DW   = 8,
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] folded;

  always_comb begin
    folded = SEED[DW-1:0];
    for (int i = 0; i < AW; i++) begin
      folded[i % DW] = folded[i % DW] ^ rd_addr[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= folded;
    end
  end
endmodule

// File: rtl/pgm_core_exec.sv
module pgm_core_exec
  import pgm_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic [OPER_W-1:0] instr,
  input  logic              inc,
  output logic [AW-1:0]     tblptr
);
  localparam int UP_W = AW - 16;

  logic [7:0]      wreg;
  logic [UP_W-1:0] ptr_u;
  logic [7:0]      ptr_h;
  logic [7:0]      ptr_l;
  logic [7:0]      opc;
  logic [7:0]      arg;

  assign opc    = instr[15:8];
  assign arg    = instr[7:0];
  assign tblptr = {ptr_u, ptr_h, ptr_l};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreg  <= '0;
      ptr_u <= '0;
      ptr_h <= '0;
      ptr_l <= '0;
    end else if (inc) begin
      {ptr_u, ptr_h, ptr_l} <= tblptr + 1'b1;
    end else if (exec) begin
      if (opc == OPC_LOADW) begin
        wreg <= arg;
      end else if (opc == OPC_STORW) begin
        case (arg)
          REG_UPPER: ptr_u <= wreg[UP_W-1:0];
          REG_HIGH:  ptr_h <= wreg;
          REG_LOW:   ptr_l <= wreg;
          default:   ;
        endcase
      end
    end
  end

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> tblptr == AW'($past(tblptr) + 1'b1));

  assert_w_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(wreg));
endmodule

// File: rtl/pgm_port_target.sv
module pgm_port_target
  import pgm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdata_in,
  output logic sdata_out,
  output logic sdata_oe
);
  localparam int CNT_W  = $clog2(OPER_W);
  localparam int HALF_W = OPER_W / 2;
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_W - 1);
  localparam logic [CNT_W-1:0] OPER_LAST = CNT_W'(OPER_W - 1);

  logic rise_evt, fall_evt, din;
  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [CMD_W-1:0]   cmd;
  logic [OPER_W-1:0]  oper;
  logic [BYTE_W-1:0]  shreg;
  logic               exec_q, inc_q, rd_q;
  logic [ADDR_W-1:0]  tblptr;
  logic               mem_valid;
  logic [BYTE_W-1:0]  mem_data;

  pgm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_raw(sclk), .data_raw(sdata_in),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .data_syn(din)
  );

  pgm_core_exec #(.AW(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .exec(exec_q), .instr(oper),
    .inc(inc_q), .tblptr(tblptr)
  );

  pgm_mem_model #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_q), .rd_addr(tblptr),
    .rd_valid(mem_valid), .rd_data(mem_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cnt      <= '0;
      cmd      <= '0;
      oper     <= '0;
      sdata_oe <= 1'b0;
      exec_q   <= 1'b0;
      inc_q    <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      exec_q <= 1'b0;
      inc_q  <= 1'b0;
      rd_q   <= 1'b0;
      if (fall_evt) begin
        case (phase)
          PH_CMD: begin
            cmd <= {din, cmd[CMD_W-1:1]};
            if (cnt == CMD_LAST) begin
              cnt   <= '0;
              phase <= PH_OPER;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_OPER: begin
            oper <= {din, oper[OPER_W-1:1]};
            if (cmd == CMD_TBLRD && cnt == HALF_LAST) begin
              cnt      <= '0;
              phase    <= PH_OUT;
              sdata_oe <= 1'b1;
              rd_q     <= 1'b1;
            end else if (cnt == OPER_LAST) begin
              cnt    <= '0;
              phase  <= PH_CMD;
              exec_q <= (cmd == CMD_CORE);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_OUT: begin
            if (cnt == HALF_LAST) begin
              cnt      <= '0;
              phase    <= PH_CMD;
              sdata_oe <= 1'b0;
              inc_q    <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      sdata_out <= 1'b0;
    end else if (mem_valid) begin
      shreg <= mem_data;
    end else if (rise_evt && phase == PH_OUT) begin
      sdata_out <= shreg[0];
      shreg     <= {1'b0, shreg[BYTE_W-1:1]};
    end
  end

  assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(fall_evt));

  assert_oe_off_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> $past(fall_evt));

  assert_out_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(sdata_out));
endmodule

// File: tb/tb_pgm_port_target.sv
module tb_pgm_port_target;
  localparam int HALF = 8;
  localparam int GAP  = 12;
  localparam int NVEC = 6;
  localparam logic [21:0] VEC_ADDR [0:NVEC-1] = '{
    22'h000010, 22'h123456, 22'h3F00FE, 22'h2A55AA, 22'h0001FF, 22'h15C3E7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic sdata_in = 1'b0;
  logic sdata_out, sdata_oe;
  int   applied = 0;
  int   errors  = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pgm_port_target dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe)
  );

  function automatic logic [7:0] memf(input logic [21:0] a);
    return 8'hA5 ^ a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    sdata_in = b;
    sclk = 1'b1;
    cyc(HALF);
    sclk = 1'b0;
    cyc(HALF);
  endtask

  task automatic send_cmd(input logic [3:0] c);
    for (int i = 0; i < 4; i++) pulse(c[i]);
  endtask

  task automatic core(input logic [15:0] op);
    send_cmd(4'b0000);
    for (int i = 0; i < 16; i++) pulse(op[i]);
    cyc(GAP);
  endtask

  task automatic set_ptr(input logic [21:0] a);
    core({8'h0E, 2'b00, a[21:16]}); core(16'h6EF8);
    core({8'h0E, a[15:8]});         core(16'h6EF7);
    core({8'h0E, a[7:0]});          core(16'h6EF6);
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic oe_early;
    oe_early = 1'b0;
    send_cmd(4'b1001);
    for (int i = 0; i < 8; i++) begin
      sdata_in = 1'b1;
      sclk = 1'b1;
      cyc(HALF);
      oe_early |= sdata_oe;
      sclk = 1'b0;
      cyc(HALF);
    end
    chk("R6 oe low in input half", {31'd0, oe_early}, 32'd0);
    cyc(GAP);
    chk("R6 oe high after turnaround", {31'd0, sdata_oe}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1;
      cyc(HALF);
      b[i] = sdata_out;
      sclk = 1'b0;
      cyc(HALF);
    end
    cyc(GAP);
    chk("R6 oe released", {31'd0, sdata_oe}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [21:0] a;
    cyc(5);
    chk("R10 oe in reset", {31'd0, sdata_oe}, 32'd0);
    chk("R10 out in reset", {31'd0, sdata_out}, 32'd0);
    rst_n = 1'b1;
    cyc(5);
    // R10 pointer zero after reset; R8 content; R7 increment
    read_byte(b); chk("R10 first read at 0", {24'd0, b}, {24'd0, memf(22'h0)});
    read_byte(b); chk("R7 next byte", {24'd0, b}, {24'd0, memf(22'h1)});

    // vector walk: R1 R2 R3 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      a = VEC_ADDR[v];
      set_ptr(a);
      read_byte(b); chk("R5 vector byte", {24'd0, b}, {24'd0, memf(a)});
      read_byte(b); chk("R7 vector next", {24'd0, b}, {24'd0, memf(a + 22'd1)});
    end

    // R3 upper byte keeps 6 bits, R7 wrap
    core(16'h0EFF); core(16'h6EF8); core(16'h6EF7); core(16'h6EF6);
    read_byte(b); chk("R3 upper masked", {24'd0, b}, {24'd0, memf(22'h3FFFFF)});
    read_byte(b); chk("R7 wrap to zero", {24'd0, b}, {24'd0, memf(22'h000000)});

    // R4 unsupported instructions ignored
    set_ptr(22'h0A0B0C);
    core(16'h0E77);
    core(16'h6EF5); core(16'h6E00); core(16'h1234); core(16'h0F99);
    read_byte(b); chk("R4 pointer untouched", {24'd0, b}, {24'd0, memf(22'h0A0B0C)});
    core(16'h6EF6);
    read_byte(b); chk("R4 W kept 77", {24'd0, b}, {24'd0, memf(22'h0A0B77)});

    // R9 unknown command: no drive, no state change
    begin
      logic oe_seen;
      oe_seen = 1'b0;
      send_cmd(4'b0101);
      for (int i = 0; i < 16; i++) begin
        sdata_in = 1'b1;
        sclk = 1'b1; cyc(HALF); oe_seen |= sdata_oe;
        sclk = 1'b0; cyc(HALF); oe_seen |= sdata_oe;
      end
      cyc(GAP);
      chk("R9 oe stays low", {31'd0, oe_seen}, 32'd0);
    end
    read_byte(b); chk("R9 pointer untouched", {24'd0, b}, {24'd0, memf(22'h0A0B78)});

    // R10 reset mid-stream
    send_cmd(4'b1001);
    rst_n = 1'b0; cyc(3);
    chk("R10 oe cleared", {31'd0, sdata_oe}, 32'd0);
    rst_n = 1'b1; cyc(5);
    read_byte(b); chk("R10 pointer cleared", {24'd0, b}, {24'd0, memf(22'h0)});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule